// File: doc/BRIEF.md
# Synchronized Four-Channel DAC Register Bank

This block holds the digital side of a four-channel analog output stage. Software writes 12-bit codes into one holding register per channel and sets a 2-bit output range for each channel in a shared range byte. The block drives four latched 12-bit codes and four 2-bit range selects to the converters. The converters and any analog scaling are outside the block.

The block has two update modes. In direct mode a code write goes to the channel's output latch on the next clock edge. In synchronous mode writes stay in the holding registers. A common update strobe then moves all four holding values into the output latches on one clock edge, so the channels step together. The strobe is either a write of any value to a dedicated byte offset or a pulse on a hardware update pin.

The write port is byte-addressed with a 16-bit data bus and two byte lanes. Lane i carries the byte at offset (word base + i) on data bits [8i+7:8i]. Reads are combinational and word-addressed.

Top module: `dac_sync_bank`

## Requirements
- R1: After reset, every output code and every holding register is 0x800 (mid-scale). Every range select is 2 (bipolar ±5 V), the range byte reads 0xAA, and synchronous mode is off.
- R2: In direct mode, a write to the code word of channel n (byte offset 2n) changes only channel n's output, on the clock edge that takes the write.
- R3: Code writes keep only bits 11:0. A read of a code word returns the holding value with bits 15:12 at zero.
- R4: Bit 0 of the byte at offset 15 selects synchronous mode (1 = on). While it is on, a code write changes the holding register and leaves the outputs unchanged.
- R5: A write of any value to byte offset 9 copies all four holding registers into the output latches on that clock edge.
- R6: A high level on `ext_update` at a clock edge has the same effect as the offset-9 strobe.
- R7: When a code write and an update strobe fall on the same edge, the output latch takes the newly written value.
- R8: The range byte is at offset 8. Channel n's select is bits 2n+1:2n. Codes: 0 = 0–5 V, 1 = 0–10 V, 2 = ±5 V, 3 = ±10 V. The byte reads back as written.
- R9: A code write with one byte lane enabled changes only that lane's bits. Lane 0 updates bits 7:0 and lane 1 updates bits 11:8.
- R10: The control word (offset 14) reads back synchronous mode on bit 8 and zero on all other bits. Writes to unmapped offsets (10 to 14) change no output and no read-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Byte address of the write (bit 0 ignored; lanes pick bytes) |
| wr_be | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data, lane i on bits [8i+7:8i] |
| ext_update | input | 1 | Hardware update strobe |
| rd_addr | input | ADDR_W | Byte address of the read word |
| rd_data | output | 16 | Combinational read data |
| dac_code_o | output | NCH*DW | Latched codes, channel n on bits [n*DW +: DW] |
| range_sel_o | output | 2*NCH | Range selects, channel n on bits [2n +: 2] |

## Verification
Every register result is due on the first rising edge after the write or strobe is presented. Read data follows `rd_addr` combinationally. The bench drives all inputs on the falling edge, lets exactly one rising edge take them, and samples outputs and read data on the next falling edge. A one-cycle slip in any latch path therefore shows up as a mismatch. The hold checks in synchronous mode sample the outputs after the edge that takes the code write, so a latch that updates early is caught in the same cycle.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

   // byte offsets whose placement software depends on
   localparam int RANGE_OFS  = 8;
   localparam int STROBE_OFS = 9;
   localparam int CTRL_OFS   = 15;

   // lane that carries each single-byte register
   localparam int RANGE_LANE  = RANGE_OFS % 2;
   localparam int STROBE_LANE = STROBE_OFS % 2;
   localparam int CTRL_LANE   = CTRL_OFS % 2;

   // word indices
   localparam int RANGE_WORD  = RANGE_OFS / 2;
   localparam int STROBE_WORD = STROBE_OFS / 2;
   localparam int CTRL_WORD   = CTRL_OFS / 2;

   typedef enum logic [1:0] {
      RNG_UNI_5  = 2'd0,
      RNG_UNI_10 = 2'd1,
      RNG_BIP_5  = 2'd2,
      RNG_BIP_10 = 2'd3
   } out_range_e;

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
   import dac_bank_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_be,
   output logic [NCH-1:0]    ch_lo_we,
   output logic [NCH-1:0]    ch_hi_we,
   output logic              rng_we,
   output logic              strobe_we,
   output logic              ctrl_we
);
   localparam int WORD_W = ADDR_W - 1;

   logic [WORD_W-1:0] word;
   logic              unused_addr_lsb;

   assign word            = wr_addr[ADDR_W-1:1];
   assign unused_addr_lsb = wr_addr[0];

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic hit;
      assign hit         = wr_en && (word == WORD_W'(n));
      assign ch_lo_we[n] = hit && wr_be[0];
      assign ch_hi_we[n] = hit && wr_be[1];
   end

   assign rng_we    = wr_en && (word == WORD_W'(RANGE_WORD))  && wr_be[RANGE_LANE];
   assign strobe_we = wr_en && (word == WORD_W'(STROBE_WORD)) && wr_be[STROBE_LANE];
   assign ctrl_we   = wr_en && (word == WORD_W'(CTRL_WORD))   && wr_be[CTRL_LANE];

endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
   parameter int          DW       = 12,
   parameter logic [DW-1:0] RST_CODE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lo_we,
   input  logic          hi_we,
   input  logic [7:0]    lo_byte,
   input  logic [DW-9:0] hi_bits,
   input  logic          direct_mode,
   input  logic          update,
   output logic [DW-1:0] hold_o,
   output logic [DW-1:0] code_o
);
   logic [DW-1:0] hold_q;
   logic [DW-1:0] hold_nxt;
   logic [DW-1:0] code_q;
   logic          take;

   always_comb begin
      hold_nxt = hold_q;
      if (lo_we) hold_nxt[7:0]    = lo_byte;
      if (hi_we) hold_nxt[DW-1:8] = hi_bits;
   end

   // the strobe samples the merged value, so a same-edge write wins
   assign take = update || (direct_mode && (lo_we || hi_we));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= RST_CODE;
         code_q <= RST_CODE;
      end else begin
         hold_q <= hold_nxt;
         if (take) code_q <= hold_nxt;
      end
   end

   assign hold_o = hold_q;
   assign code_o = code_q;

endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs #(
   parameter int         NCH      = 4,
   parameter logic [1:0] RNG_RST  = 2'd2,
   parameter logic       SYNC_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rng_we,
   input  logic [2*NCH-1:0] rng_bits,
   input  logic             ctrl_we,
   input  logic             ctrl_bit,
   output logic [2*NCH-1:0] range_o,
   output logic             sync_o
);
   logic [2*NCH-1:0] range_q;
   logic             sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         range_q <= {NCH{RNG_RST}};
         sync_q  <= SYNC_RST;
      end else begin
         if (rng_we)  range_q <= rng_bits;
         if (ctrl_we) sync_q  <= ctrl_bit;
      end
   end

   assign range_o = range_q;
   assign sync_o  = sync_q;

endmodule

// File: rtl/dac_rd_mux.sv
module dac_rd_mux
   import dac_bank_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DW     = 12,
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [NCH*DW-1:0] hold_flat,
   input  logic [2*NCH-1:0]  range_q,
   input  logic              sync_q,
   output logic [15:0]       rd_data
);
   localparam int WORD_W = ADDR_W - 1;

   logic [WORD_W-1:0] word;
   logic              unused_rd_lsb;

   assign word          = rd_addr[ADDR_W-1:1];
   assign unused_rd_lsb = rd_addr[0];

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NCH; k++) begin
         if (word == WORD_W'(k)) rd_data[DW-1:0] = hold_flat[k*DW +: DW];
      end
      // the strobe byte shares this word and always reads zero
      if (word == WORD_W'(RANGE_WORD)) rd_data[8*RANGE_LANE +: 2*NCH] = range_q;
      if (word == WORD_W'(CTRL_WORD))  rd_data[8*CTRL_LANE] = sync_q;
   end

endmodule

// File: rtl/dac_sync_bank.sv
module dac_sync_bank
   import dac_bank_pkg::*;
#(
   parameter int         NCH      = 4,
   parameter int         DW       = 12,
   parameter int         ADDR_W   = 4,
   parameter logic [1:0] RNG_RST  = 2'd2,
   parameter logic       SYNC_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_be,
   input  logic [15:0]       wr_data,
   input  logic              ext_update,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic [NCH*DW-1:0] dac_code_o,
   output logic [2*NCH-1:0]  range_sel_o
);
   localparam int            HI_W     = DW - 8;
   localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

   // elaboration-time parameter checks
   if (DW < 9 || DW > 16) begin : g_bad_dw
      $error("dac_sync_bank: DW must lie in 9..16");
   end
   if (NCH < 1 || 2*NCH > 8) begin : g_bad_nch
      $error("dac_sync_bank: range fields must fit one byte");
   end
   if (2*NCH > RANGE_OFS) begin : g_bad_map
      $error("dac_sync_bank: code words overlap the range byte");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("dac_sync_bank: address too narrow for the control byte");
   end

   logic [NCH-1:0]    ch_lo_we;
   logic [NCH-1:0]    ch_hi_we;
   logic              rng_we;
   logic              strobe_we;
   logic              ctrl_we;
   logic              sync_q;
   logic              upd_all;
   logic [2*NCH-1:0]  range_q;
   logic [NCH*DW-1:0] hold_flat;
   logic [15-8-HI_W:0] unused_wr_hi;

   assign unused_wr_hi = wr_data[15:8+HI_W];

   dac_wr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .ch_lo_we  (ch_lo_we),
      .ch_hi_we  (ch_hi_we),
      .rng_we    (rng_we),
      .strobe_we (strobe_we),
      .ctrl_we   (ctrl_we)
   );

   assign upd_all = strobe_we || ext_update;

   for (genvar n = 0; n < NCH; n++) begin : g_slot
      dac_chan_slot #(.DW(DW), .RST_CODE(MID_CODE)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .lo_we       (ch_lo_we[n]),
         .hi_we       (ch_hi_we[n]),
         .lo_byte     (wr_data[7:0]),
         .hi_bits     (wr_data[8 +: HI_W]),
         .direct_mode (!sync_q),
         .update      (upd_all),
         .hold_o      (hold_flat[n*DW +: DW]),
         .code_o      (dac_code_o[n*DW +: DW])
      );
   end

   dac_cfg_regs #(.NCH(NCH), .RNG_RST(RNG_RST), .SYNC_RST(SYNC_RST)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .rng_we   (rng_we),
      .rng_bits (wr_data[8*RANGE_LANE +: 2*NCH]),
      .ctrl_we  (ctrl_we),
      .ctrl_bit (wr_data[8*CTRL_LANE]),
      .range_o  (range_q),
      .sync_o   (sync_q)
   );

   assign range_sel_o = range_q;

   dac_rd_mux #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr   (rd_addr),
      .hold_flat (hold_flat),
      .range_q   (range_q),
      .sync_q    (sync_q),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/dac_sync_bank_chk.sv
module dac_sync_bank_chk
   import dac_bank_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DW     = 12,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [1:0]        wr_be,
   input logic              ext_update,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [15:0]       rd_data,
   input logic [NCH*DW-1:0] dac_code_o,
   input logic [2*NCH-1:0]  range_sel_o,
   input logic              sync_mode,
   input logic [NCH*DW-1:0] hold_flat
);
   localparam int WORD_W = ADDR_W - 1;

   logic [WORD_W-1:0] w_word;
   logic [WORD_W-1:0] r_word;
   logic              data_wr;
   logic              upd;
   logic              rng_wr;
   logic              unused_lsbs;

   assign w_word      = wr_addr[ADDR_W-1:1];
   assign r_word      = rd_addr[ADDR_W-1:1];
   assign unused_lsbs = wr_addr[0] ^ rd_addr[0];
   assign data_wr     = wr_en && (w_word < WORD_W'(NCH)) && (|wr_be);
   assign upd         = ext_update || (wr_en && (w_word == WORD_W'(STROBE_WORD)) && wr_be[STROBE_LANE]);
   assign rng_wr      = wr_en && (w_word == WORD_W'(RANGE_WORD)) && wr_be[RANGE_LANE];

   // R2: without a code write or a strobe, no output code moves
   p_direct_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !data_wr) |=> $stable(dac_code_o));

   // R4: in synchronous mode only a strobe moves the outputs
   p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !upd) |=> $stable(dac_code_o));

   // R5 / R6: a strobe with no code write copies every holding register
   p_update_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !data_wr) |=> (dac_code_o == $past(hold_flat)));

   // R8: range selects change only through the range byte
   p_range_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rng_wr |=> $stable(range_sel_o));

   // R3: code-word read-back has its upper bits clear
   p_data_rb_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (r_word < WORD_W'(NCH)) |-> (rd_data[15:DW] == '0));

endmodule

bind dac_sync_bank dac_sync_bank_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_be       (wr_be),
   .ext_update  (ext_update),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .dac_code_o  (dac_code_o),
   .range_sel_o (range_sel_o),
   .sync_mode   (sync_q),
   .hold_flat   (hold_flat)
);

// File: tb/dac_sync_bank_tb.sv
module dac_sync_bank_tb;
   localparam int NCH = 4;
   localparam int DW  = 12;
   localparam int AW  = 4;
   localparam int NV  = 15;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [1:0]        wr_be;
   logic [15:0]       wr_data;
   logic              ext_update;
   logic [AW-1:0]     rd_addr;
   logic [15:0]       rd_data;
   logic [NCH*DW-1:0] dac_code_o;
   logic [2*NCH-1:0]  range_sel_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dac_sync_bank u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_be       (wr_be),
      .wr_data     (wr_data),
      .ext_update  (ext_update),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .dac_code_o  (dac_code_o),
      .range_sel_o (range_sel_o)
   );

   // {addr, be, data, ext, check channel, expected code}
   localparam logic [36:0] VEC [NV] = '{
      {4'h0, 2'b11, 16'h0123, 1'b0, 2'd0, 12'h123},
      {4'h2, 2'b11, 16'hFABC, 1'b0, 2'd1, 12'hABC},
      {4'h4, 2'b01, 16'h0055, 1'b0, 2'd2, 12'h855},
      {4'h6, 2'b10, 16'h0300, 1'b0, 2'd3, 12'h300},
      {4'hE, 2'b10, 16'h0100, 1'b0, 2'd0, 12'h123},
      {4'h0, 2'b11, 16'h0456, 1'b0, 2'd0, 12'h123},
      {4'h2, 2'b11, 16'h0777, 1'b0, 2'd1, 12'hABC},
      {4'h8, 2'b10, 16'h5A00, 1'b0, 2'd0, 12'h456},
      {4'h4, 2'b00, 16'h0000, 1'b0, 2'd1, 12'h777},
      {4'h4, 2'b11, 16'h0999, 1'b1, 2'd2, 12'h999},
      {4'h6, 2'b11, 16'h0AAA, 1'b0, 2'd3, 12'h300},
      {4'hA, 2'b11, 16'hFFFF, 1'b0, 2'd3, 12'h300},
      {4'h0, 2'b00, 16'h0000, 1'b1, 2'd3, 12'hAAA},
      {4'hE, 2'b10, 16'h0000, 1'b0, 2'd0, 12'h456},
      {4'h6, 2'b11, 16'h0001, 1'b0, 2'd3, 12'h001}
   };
   localparam string VREQ [NV] = '{
      "R2", "R3", "R9", "R9", "R4", "R4", "R4", "R5",
      "R5", "R7", "R4", "R10", "R6", "R2", "R2"
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d, input logic e);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; ext_update = e;
      @(negedge clk);
      wr_en = 1'b0; wr_be = 2'b00; ext_update = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [3:0] a, input logic [15:0] exp);
      rd_addr = a;
      #1;
      check(req, 32'(rd_data), 32'(exp));
   endtask

   function automatic logic [DW-1:0] code_of(input int ch);
      return dac_code_o[ch*DW +: DW];
   endfunction

   function automatic logic [1:0] rng_of(input int ch);
      return range_sel_o[ch*2 +: 2];
   endfunction

   task automatic reset_checks();
      for (int c = 0; c < NCH; c++) begin
         check("R1", 32'(code_of(c)), 32'h800);
         check("R1", 32'(rng_of(c)), 32'd2);
      end
      rd_check("R1", 4'h8, 16'h00AA);
      rd_check("R1", 4'hE, 16'h0000);
      rd_check("R1", 4'h0, 16'h0800);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_be = '0;
      wr_data = '0; ext_update = 1'b0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reset_checks();

      // table walk: direct writes, lanes, sync hold, strobes
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  a;
         logic [1:0]  be;
         logic [15:0] d;
         logic        e;
         logic [1:0]  ch;
         logic [11:0] x;
         {a, be, d, e, ch, x} = VEC[i];
         wr(a, be, d, e);
         check(VREQ[i], 32'(code_of(int'(ch))), 32'(x));
      end

      // R3: read-back of code words, upper bits clear
      rd_check("R3", 4'h2, 16'h0777);
      rd_check("R3", 4'h6, 16'h0001);

      // R8: range byte written alone, upper lane ignored
      wr(4'h8, 2'b01, 16'hFFE4, 1'b0);
      check("R8", 32'(rng_of(0)), 32'd0);
      check("R8", 32'(rng_of(1)), 32'd1);
      check("R8", 32'(rng_of(2)), 32'd2);
      check("R8", 32'(rng_of(3)), 32'd3);
      rd_check("R8", 4'h8, 16'h00E4);
      check("R5", 32'(code_of(0)), 32'h456);

      // R10: control read-back keeps only bit 0
      wr(4'hF, 2'b10, 16'hFF00, 1'b0);
      rd_check("R10", 4'hE, 16'h0100);

      // R10: unmapped write touches nothing
      wr(4'hC, 2'b11, 16'hFFFF, 1'b0);
      rd_check("R10", 4'h8, 16'h00E4);
      rd_check("R10", 4'hE, 16'h0100);
      check("R10", 32'(code_of(1)), 32'h777);

      // R8: full word write sets range and strobes together
      wr(4'h8, 2'b11, 16'h001B, 1'b0);
      check("R8", 32'(rng_of(0)), 32'd3);
      check("R8", 32'(rng_of(3)), 32'd0);
      check("R5", 32'(code_of(2)), 32'h999);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      reset_checks();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule